// File: doc/BRIEF.md
# Serial Flash Command Shift Engine

This block issues arbitrary serial NOR flash commands that software builds byte by byte. A seven-byte window holds the bytes to send: the command byte goes in slot 5 and any address or dummy bytes follow in slots 4 down to 0. A separate register holds the total number of serial clock bits for the whole transaction. That total covers the bits sent and the bits read back. Nothing happens until software writes the execute command.

During a transfer the window works as one shift register. Each serial clock moves the window left by one bit. The bit leaving the transmit tap, which is bit 7 of slot 5, drives MOSI, and the bit sampled from MISO enters at bit 0. When the bit count is reached, chip select rises and the done flag is set. The bytes received last now sit in the lowest slots, and the most recent byte is in slot 0. Software reads them back through the same byte-wide register port. The window keeps its contents until software writes it again.

The serial clock is the system clock divided by four and follows SPI mode 0. MISO is sampled on the rising edge and MOSI changes on the falling edge.

Top module: `spi_prog_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, busy and done are 0, and every window slot and the count register read as 0.
- R2: Writing 1 to bit 0 of address 8 while the engine is idle, with a count from 1 to 56, starts a transfer. Chip select is low from the first cycle after the write. Each bit then takes 4 clocks: SCK is low for 2 clocks, then high for 2 clocks. After exactly the programmed number of SCK pulses, chip select returns high.
- R3: The first MOSI bit is bit 7 of slot 5, which is bit 47 of the 56-bit window. Later bits follow MSB first through slots 4 down to 0. While chip select is low, MOSI changes only when SCK falls.
- R4: MISO is sampled as SCK rises and enters at window bit 0. After N bits the window equals its old value shifted left by N, with the received bits in the low N bits, so the most recent byte is in slot 0. Bits shifted past the tap move into slot 6, and any bits that pass bit 55 are lost.
- R5: Busy is high from the cycle after a valid execute until the cycle in which chip select rises. In that cycle done becomes 1. Done and busy are never high together, and the next execute clears done.
- R6: While busy, writes to slots 0 to 6 (addresses 0 to 6), to the count (address 7) and to the execute command (address 8) have no effect.
- R7: An execute with a count of 0 or more than 56 leaves chip select high and busy low. It sets done on the next cycle and leaves the window unchanged.
- R8: Reads return the window slot at addresses 0 to 6 and the count at address 7. Address 9 returns status, with busy in bit 0 and done in bit 1. After a transfer the window holds its contents until software writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, system clock divided by 4 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer or no-op execute has finished |

## Verification
Two situations are hard to reach from the ports. One is a register write that lands in the middle of a transfer, at a chosen SCK phase. The bench reaches it by driving count, slot and execute writes at fixed cycle offsets inside a running transfer. It then reads back the count and the final window. The other is a full 56-bit transfer: received bits cross the transmit tap and are sent out again, and the original opcode ends up beyond slot 6. The reference model drives that case with a 56-bit receive pattern, so the late MOSI bits come from the received data.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;
    // default geometry of the command window
    localparam int unsigned SLOT_CNT = 7;
    localparam int unsigned OPC_SLOT = 5;
    localparam int unsigned CNT_W    = 8;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned HALF_DIV = 2;
    // status register bit positions
    localparam int unsigned STAT_BUSY = 0;
    localparam int unsigned STAT_DONE = 1;
endpackage

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic rise_next,
    output logic fall_next
);
    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            sck;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (run) begin
            nxt_d.ph = (cur_q.ph == PH_LAST) ? '0 : cur_q.ph + PH_W'(1);
        end else begin
            nxt_d.ph = '0;
        end
        nxt_d.sck = run && (nxt_d.ph >= PH_HIGH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sck       = cur_q.sck;
    assign rise_next = run && (cur_q.ph == PH_RISE);
    assign fall_next = run && (cur_q.ph == PH_LAST);

    // R2
    sck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_next |=> sck);
    // R2
    sck_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_next |=> !sck);
endmodule

// File: rtl/spi_shift_window.sv
module spi_shift_window #(
    parameter int unsigned SLOTS = 7,
    parameter int unsigned TAP   = 47
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(SLOTS)-1:0]     wr_idx,
    input  logic [7:0]                   wr_byte,
    input  logic                         sample_en,
    input  logic                         miso,
    input  logic                         shift_en,
    output logic [SLOTS*8-1:0]           win,
    output logic                         tx_bit
);
    localparam int unsigned WIN_W = SLOTS * 8;
    localparam int unsigned IDX_W = $clog2(SLOTS);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             rx;
    } win_t;

    win_t cur_q, nxt_d;
    logic [SLOTS-1:0] slot_hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign slot_hit[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        nxt_d = cur_q;
        if (sample_en) begin
            nxt_d.rx = miso;
        end
        if (shift_en) begin
            nxt_d.win = {cur_q.win[WIN_W-2:0], cur_q.rx};
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_hit[i]) begin
                    nxt_d.win[i*8 +: 8] = wr_byte;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign win    = cur_q.win;
    assign tx_bit = cur_q.win[TAP];

    // R3
    tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !wr_en) |=> $stable(tx_bit));
endmodule

// File: rtl/spi_prog_ctrl.sv
module spi_prog_ctrl #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned MAX_BITS = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             fall,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             shift_en
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic             cs_n;
        logic [CNT_W-1:0] bits;
    } ctl_t;

    ctl_t cur_q, nxt_d;
    logic             count_ok;
    logic [CNT_W-1:0] bits_inc;

    assign count_ok = (count != '0) && (count <= CNT_W'(MAX_BITS));
    assign bits_inc = cur_q.bits + CNT_W'(1);
    assign shift_en = cur_q.busy && fall;

    always_comb begin
        nxt_d = cur_q;
        if (start && !cur_q.busy) begin
            nxt_d.busy = count_ok;
            nxt_d.cs_n = !count_ok;
            nxt_d.done = !count_ok;
            nxt_d.bits = '0;
        end else if (shift_en) begin
            nxt_d.bits = bits_inc;
            if (bits_inc == count) begin
                nxt_d.busy = 1'b0;
                nxt_d.cs_n = 1'b1;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{busy: 1'b0, done: 1'b0, cs_n: 1'b1, bits: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy = cur_q.busy;
    assign done = cur_q.done;
    assign cs_n = cur_q.cs_n;

    // R7
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cur_q.busy && (count == '0)) |=> (cs_n && done && !busy));
    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    // R2
    bit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cur_q.bits < count));
endmodule

// File: rtl/spi_prog_engine.sv
module spi_prog_engine
    import spi_prog_pkg::*;
#(
    parameter int unsigned SLOTS   = SLOT_CNT,
    parameter int unsigned OPC_IDX = OPC_SLOT,
    parameter int unsigned CW      = CNT_W,
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned HALF    = HALF_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic          reg_wr,
    output logic [7:0]    reg_rdata,
    output logic          spi_cs_n,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic          busy,
    output logic          done
);
    localparam int unsigned WIN_W = SLOTS * 8;
    localparam int unsigned TAP   = OPC_IDX * 8 + 7;
    localparam int unsigned IDX_W = $clog2(SLOTS);
    localparam logic [AW-1:0] A_COUNT = AW'(SLOTS);
    localparam logic [AW-1:0] A_CMD   = AW'(SLOTS + 1);
    localparam logic [AW-1:0] A_STAT  = AW'(SLOTS + 2);

    typedef struct packed {
        logic [CW-1:0] count;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic             slot_wr, start, shift_en, rise_next, fall_next;
    logic [WIN_W-1:0] win;

    assign slot_wr = reg_wr && !busy && (reg_addr < AW'(SLOTS));
    assign start   = reg_wr && !busy && (reg_addr == A_CMD) && reg_wdata[0];

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && !busy && (reg_addr == A_COUNT)) begin
            cfg_d.count = CW'(reg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    spi_bit_timer #(.HALF(HALF)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .sck       (spi_sck),
        .rise_next (rise_next),
        .fall_next (fall_next)
    );

    spi_shift_window #(.SLOTS(SLOTS), .TAP(TAP)) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (slot_wr),
        .wr_idx    (reg_addr[IDX_W-1:0]),
        .wr_byte   (reg_wdata),
        .sample_en (rise_next),
        .miso      (spi_miso),
        .shift_en  (shift_en),
        .win       (win),
        .tx_bit    (spi_mosi)
    );

    spi_prog_ctrl #(.CNT_W(CW), .MAX_BITS(WIN_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .count    (cfg_q.count),
        .fall     (fall_next),
        .busy     (busy),
        .done     (done),
        .cs_n     (spi_cs_n),
        .shift_en (shift_en)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (reg_addr == AW'(i)) begin
                reg_rdata = win[i*8 +: 8];
            end
        end
        if (reg_addr == A_COUNT) begin
            reg_rdata = 8'(cfg_q.count);
        end
        if (reg_addr == A_STAT) begin
            reg_rdata[STAT_BUSY] = busy;
            reg_rdata[STAT_DONE] = done;
        end
    end

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && (reg_addr == A_COUNT)) |=> $stable(cfg_q.count));
    // R6
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en) |=> $stable(win));
    // R2
    sck_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_cs_n);
    // R3
    mosi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !$fell(spi_sck)) |-> $stable(spi_mosi));
endmodule

// File: tb/test_spi_prog_engine.sv
module test_spi_prog_engine;
    localparam int TAP = 47;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi, busy, done;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] win_m [7];
    logic [7:0] cnt_m;

    always #4 clk = ~clk;

    spi_prog_engine i_spi_prog_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 4'd7) win_m[a] = d;
        if (a == 4'd7) cnt_m = d;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_window(input string req);
        logic [7:0] rd;
        for (int i = 0; i < 7; i++) begin
            bus_read(4'(i), rd);
            check(req, rd, win_m[i]);
        end
    endtask

    // Reference model: every clock of the transfer is predicted from the window contents
    task automatic run_xfer(input int n, input logic [63:0] rxpat, input bit disturb);
        logic [63:0] v, r, fin;
        logic [7:0]  rd;
        logic        eb;
        v = '0;
        for (int i = 0; i < 7; i++) v = v | (64'(win_m[i]) << (8 * i));
        r = rxpat & ((64'd1 << n) - 64'd1);
        fin = ((v << n) | r) & ((64'd1 << 56) - 64'd1);
        @(negedge clk);
        reg_addr = 4'd8; reg_wdata = 8'h01; reg_wr = 1'b1;
        for (int t = 0; t <= 4 * n; t++) begin
            @(negedge clk);
            if (t == 0) reg_wr = 1'b0;
            if (t < 4 * n) begin
                int j;
                j = t / 4;
                eb = (j <= TAP) ? v[TAP - j] : r[n - 1 - (j - TAP - 1)];
                // R2 R3 R5: cs low, sck 2 low/2 high, mosi bit, busy set, done clear
                check("R2/R3/R5 waveform", {59'd0, spi_cs_n, spi_sck, spi_mosi, busy, done},
                      {59'd0, 1'b0, ((t % 4) >= 2), eb, 1'b1, 1'b0});
                if ((t % 4) == 0) spi_miso = r[n - 1 - j];
                if (t == 1) begin
                    bus_read(4'd9, rd);
                    check("R8 status busy", rd, 8'h01);
                end
                if (disturb) begin
                    if (t == 3) begin reg_addr = 4'd7; reg_wdata = 8'h03; reg_wr = 1'b1; end
                    if (t == 4) begin reg_addr = 4'd5; reg_wdata = 8'hEE; end
                    if (t == 5) begin reg_addr = 4'd8; reg_wdata = 8'h01; end
                    if (t == 6) begin
                        reg_wr = 1'b0;
                        bus_read(4'd7, rd);
                        check("R6 count held while busy", rd, cnt_m);
                    end
                end
            end else begin
                check("R2/R5 end of transfer", {60'd0, spi_cs_n, spi_sck, busy, done},
                      {60'd0, 4'b1001});
            end
        end
        for (int i = 0; i < 7; i++) win_m[i] = fin[8*i +: 8];
        // R4 R6 R8: window after shift, rx in low bits, held for readback
        check_window("R4/R6 window after transfer");
        repeat (3) @(negedge clk);
        check("R5 idle after transfer", {62'd0, spi_cs_n, spi_sck}, {62'd0, 2'b10});
        check_window("R8 window retained");
        bus_read(4'd9, rd);
        check("R8 status done", rd, 8'h02);
    endtask

    task automatic bad_exec(input logic [7:0] n);
        bus_write(4'd7, n);
        @(negedge clk);
        reg_addr = 4'd8; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R7 bad count no-op", {60'd0, spi_cs_n, spi_sck, busy, done}, {60'd0, 4'b1001});
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R7 cs stays high", {62'd0, spi_cs_n, busy}, {62'd0, 2'b10});
        end
        check_window("R7 window unchanged");
    endtask

    initial begin
        logic [7:0] rd;
        for (int i = 0; i < 7; i++) win_m[i] = 8'h00;
        cnt_m = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pins after reset", {60'd0, spi_cs_n, spi_sck, busy, done}, {60'd0, 4'b1000});
        check_window("R1 window after reset");
        bus_read(4'd7, rd);
        check("R1 count after reset", rd, 8'h00);
        bus_read(4'd9, rd);
        check("R1 status after reset", rd, 8'h00);

        // full 56-bit read-id style transfer
        bus_write(4'd5, 8'h9F);
        bus_write(4'd7, 8'd56);
        run_xfer(56, 64'h00A5_C220_18AB_1234, 1'b0);

        // opcode plus three address bytes, one byte read back
        bus_write(4'd6, 8'h00);
        bus_write(4'd5, 8'h03);
        bus_write(4'd4, 8'h12);
        bus_write(4'd3, 8'h34);
        bus_write(4'd2, 8'h56);
        bus_write(4'd7, 8'd40);
        run_xfer(40, 64'h0000_005A_3C96_E17B, 1'b0);

        // single bit transfer
        bus_write(4'd5, 8'h80);
        bus_write(4'd7, 8'd1);
        run_xfer(1, 64'h1, 1'b0);

        // writes during a transfer are dropped
        bus_write(4'd5, 8'h06);
        bus_write(4'd7, 8'd16);
        run_xfer(16, 64'h0000_0000_0000_C3A1, 1'b1);

        // invalid counts
        bad_exec(8'd0);
        bad_exec(8'd57);

        // a valid transfer still works after the no-ops
        bus_write(4'd5, 8'h05);
        bus_write(4'd7, 8'd16);
        run_xfer(16, 64'h0000_0000_0000_00F0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule